// File: doc/BRIEF.md
# Snooping Invalidate Coherence Controller

This block keeps one small write-back cache line store coherent with its peers on a shared snooping bus. Each line carries a tag, a data word and one of three states: Invalid, Valid (clean copy) or Modified (this cache alone holds the current value, and memory is stale). Processor reads and writes are served from the local store. A miss or a write that needs ownership puts a request on the bus, so that the other caches see it before memory answers.

Requests from other caches arrive on the snoop port. A snooped read that finds a Modified line makes this controller hand over the data and write it to memory, and the line drops to Valid. A snooped invalidate removes the local copy; if that copy was Modified, its data is supplied and written back first. Replacing a Modified line on a miss also writes it back. Replacing a Valid line is silent.

The store is direct-mapped. The low address bits pick the line and the rest form the tag. Bus arbitration and the fill path are outside the block: the bus returns fill data in the same cycle as the request.

Top module: `coh_snoop_ctl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses. `cpu_done`, `wb_valid` and `snp_supply` are low.
- R2: A processor read (`cpu_write`=0) that misses drives `bus_req_valid`=1 with `bus_req_cmd`=2'b01 (read) and `bus_req_addr`=`cpu_addr` in the same cycle. The line takes `bus_fill_data` and becomes Valid. In the next cycle `cpu_done`=1 and `cpu_rdata` equals the fill data. Line states are encoded Invalid 2'b00, Valid 2'b01, Modified 2'b10.
- R3: A processor read that hits (same tag, state not Invalid) raises no bus request. In the next cycle it returns the line's stored data with `cpu_done`=1.
- R4: A processor write to a line that is Invalid, Valid or held under another tag drives `bus_req_cmd`=2'b10 (read-exclusive, which invalidates other copies) in the same cycle. A write to a Modified line with the same tag raises no bus request. After either write the line is Modified and holds `cpu_wdata`.
- R5: A processor miss whose line is Modified under another tag raises `wb_valid` in the next cycle, with that line's old address and data on `wb_addr`/`wb_data`. A miss that replaces a Valid line raises no write-back.
- R6: A snooped read (`snp_cmd`=0) that hits a Modified line raises `snp_supply` and `wb_valid` in the next cycle. Both carry the line data, and `wb_addr` is the snooped address. The line becomes Valid, so a second snooped read supplies nothing and a processor read still hits.
- R7: A snooped invalidate (`snp_cmd`=1) that hits a line makes it Invalid, so the next processor read misses. If the line was Modified, it also raises `snp_supply` and `wb_valid` with its data in the next cycle. If the line was Valid, it raises neither.
- R8: A snoop that misses (line Invalid or a different tag), and a snooped read that hits a Valid line, raise neither `snp_supply` nor `wb_valid` and leave the line unchanged.
- R9: While `snp_valid` is high, `cpu_ready` is low and a processor request is not taken: there is no bus request and no `cpu_done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | Request taken this cycle (low while a snoop is served) |
| cpu_done | output | 1 | Request completed, one cycle after it was taken |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req_valid | output | 1 | Bus request this cycle |
| bus_req_cmd | output | 2 | 2'b01 read, 2'b10 read-exclusive |
| bus_req_addr | output | ADDR_W | Bus request address |
| bus_fill_data | input | DATA_W | Data returned by peers or memory for a read request |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_cmd | input | 1 | 0 = read, 1 = invalidate |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the line to the bus |
| snp_data | output | DATA_W | Supplied data |
| wb_valid | output | 1 | Write-back to memory |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |

## Verification
The bench walks one line through every state change and watches for a bus request on a write to a line that is already Modified. A design that did not track ownership would issue that request, while one that never sent read-exclusive would leave stale peer copies. It snoops a Modified line twice. A design that left the line Modified after supplying it would answer the second snoop too. A design that lost the data would fail the processor read that follows. It evicts both a Valid and a Modified line, which catches a write-back that is missing or spurious. It also runs a snoop and a processor request in the same cycle and runs snoops that miss on a tag mismatch, so a design that took the processor request, or that compared only the index, shows it at the ports.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_VAL = 2'b01,
      LS_MOD = 2'b10
   } line_st_t;

   typedef enum logic [1:0] {
      BC_NONE = 2'b00,
      BC_READ = 2'b01,
      BC_RDX  = 2'b10
   } bus_cmd_t;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
   import coh_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int TAG_W     = 6,
   parameter int DATA_W    = 16,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  line_st_t                  wr_st,
   input  logic [TAG_W-1:0]          wr_tag,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic [IDX_W-1:0]          a_idx,
   output line_st_t                  a_st,
   output logic [TAG_W-1:0]          a_tag,
   output logic [DATA_W-1:0]         a_data,
   input  logic [IDX_W-1:0]          b_idx,
   output line_st_t                  b_st,
   output logic [TAG_W-1:0]          b_tag,
   output logic [DATA_W-1:0]         b_data,
   output logic [NUM_LINES-1:0][1:0] st_vec
);
   line_st_t            st_q   [NUM_LINES];
   logic [TAG_W-1:0]    tag_q  [NUM_LINES];
   logic [DATA_W-1:0]   data_q [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g]   <= LS_INV;
            tag_q[g]  <= '0;
            data_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            st_q[g]   <= wr_st;
            tag_q[g]  <= wr_tag;
            data_q[g] <= wr_data;
         end
      end
      assign st_vec[g] = st_q[g];
   end

   assign a_st   = st_q[a_idx];
   assign a_tag  = tag_q[a_idx];
   assign a_data = data_q[a_idx];
   assign b_st   = st_q[b_idx];
   assign b_tag  = tag_q[b_idx];
   assign b_data = data_q[b_idx];
endmodule

// File: rtl/coh_policy.sv
module coh_policy
   import coh_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   localparam int ADDR_W = TAG_W + IDX_W
) (
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  line_st_t          cl_st,
   input  logic [TAG_W-1:0]  cl_tag,
   input  logic [DATA_W-1:0] cl_data,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              snp_valid,
   input  logic              snp_inv,
   input  logic [TAG_W-1:0]  snp_tag,
   input  logic [IDX_W-1:0]  snp_idx,
   input  line_st_t          sl_st,
   input  logic [TAG_W-1:0]  sl_tag,
   input  logic [DATA_W-1:0] sl_data,
   output logic              cpu_hit,
   output logic              snp_hit,
   output bus_cmd_t          bus_cmd,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output line_st_t          wr_st,
   output logic [TAG_W-1:0]  wr_tag,
   output logic [DATA_W-1:0] wr_data,
   output logic              done_d,
   output logic [DATA_W-1:0] rdata_d,
   output logic              wb_d,
   output logic [ADDR_W-1:0] wb_addr_d,
   output logic [DATA_W-1:0] wb_data_d,
   output logic              sup_d
);
   assign cpu_hit = (cl_st != LS_INV) && (cl_tag == cpu_tag);
   assign snp_hit = (sl_st != LS_INV) && (sl_tag == snp_tag);

   always_comb begin
      bus_cmd   = BC_NONE;
      wr_en     = 1'b0;
      wr_idx    = cpu_idx;
      wr_st     = cl_st;
      wr_tag    = cl_tag;
      wr_data   = cl_data;
      done_d    = 1'b0;
      rdata_d   = '0;
      wb_d      = 1'b0;
      wb_addr_d = '0;
      wb_data_d = '0;
      sup_d     = 1'b0;
      if (snp_valid) begin
         wr_idx  = snp_idx;
         wr_tag  = sl_tag;
         wr_data = sl_data;
         wr_st   = sl_st;
         if (snp_hit && (sl_st == LS_MOD)) begin
            sup_d     = 1'b1;
            wb_d      = 1'b1;
            wb_addr_d = {snp_tag, snp_idx};
            wb_data_d = sl_data;
            wr_en     = 1'b1;
            wr_st     = LS_VAL;
         end
         if (snp_hit && snp_inv) begin
            wr_en = 1'b1;
            wr_st = LS_INV;
         end
      end else if (cpu_valid) begin
         done_d = 1'b1;
         if (cpu_write) begin
            wr_en   = 1'b1;
            wr_st   = LS_MOD;
            wr_tag  = cpu_tag;
            wr_data = cpu_wdata;
            if (!(cpu_hit && (cl_st == LS_MOD)))
               bus_cmd = BC_RDX;
         end else if (cpu_hit) begin
            rdata_d = cl_data;
         end else begin
            bus_cmd = BC_READ;
            wr_en   = 1'b1;
            wr_st   = LS_VAL;
            wr_tag  = cpu_tag;
            wr_data = fill_data;
            rdata_d = fill_data;
         end
         if (!cpu_hit && (cl_st == LS_MOD)) begin
            wb_d      = 1'b1;
            wb_addr_d = {cl_tag, cpu_idx};
            wb_data_d = cl_data;
         end
      end
   end
endmodule

// File: rtl/coh_snoop_ctl.sv
module coh_snoop_ctl
   import coh_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int NUM_LINES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_cmd,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic [DATA_W-1:0] bus_fill_data,
   input  logic              snp_valid,
   input  logic              snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_data,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [DATA_W-1:0] wb_data
);
   localparam int IDX_W = $clog2(NUM_LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0]  cpu_idx, snp_idx;
   logic [TAG_W-1:0]  cpu_tag, snp_tag;
   line_st_t          cl_st, sl_st, wr_st;
   logic [TAG_W-1:0]  cl_tag, sl_tag, wr_tag;
   logic [DATA_W-1:0] cl_data, sl_data, wr_data;
   logic              wr_en, cpu_hit, snp_hit;
   logic [IDX_W-1:0]  wr_idx;
   logic [NUM_LINES-1:0][1:0] st_vec;
   bus_cmd_t          bus_cmd;
   logic              done_d, wb_d, sup_d;
   logic [DATA_W-1:0] rdata_d, wb_data_d;
   logic [ADDR_W-1:0] wb_addr_d;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

   coh_line_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data),
      .a_idx(cpu_idx), .a_st(cl_st), .a_tag(cl_tag), .a_data(cl_data),
      .b_idx(snp_idx), .b_st(sl_st), .b_tag(sl_tag), .b_data(sl_data),
      .st_vec(st_vec)
   );

   coh_policy #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_policy (
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
      .cpu_wdata(cpu_wdata), .cl_st(cl_st), .cl_tag(cl_tag), .cl_data(cl_data),
      .fill_data(bus_fill_data), .snp_valid(snp_valid), .snp_inv(snp_cmd),
      .snp_tag(snp_tag), .snp_idx(snp_idx), .sl_st(sl_st), .sl_tag(sl_tag), .sl_data(sl_data),
      .cpu_hit(cpu_hit), .snp_hit(snp_hit), .bus_cmd(bus_cmd),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data),
      .done_d(done_d), .rdata_d(rdata_d), .wb_d(wb_d), .wb_addr_d(wb_addr_d),
      .wb_data_d(wb_data_d), .sup_d(sup_d)
   );

   assign cpu_ready     = !snp_valid;
   assign bus_req_valid = (bus_cmd != BC_NONE);
   assign bus_req_cmd   = bus_cmd;
   assign bus_req_addr  = cpu_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_done   <= 1'b0;
         cpu_rdata  <= '0;
         wb_valid   <= 1'b0;
         wb_addr    <= '0;
         wb_data    <= '0;
         snp_supply <= 1'b0;
         snp_data   <= '0;
      end else begin
         cpu_done   <= done_d;
         cpu_rdata  <= rdata_d;
         wb_valid   <= wb_d;
         wb_addr    <= wb_addr_d;
         wb_data    <= wb_data_d;
         snp_supply <= sup_d;
         snp_data   <= sup_d ? sl_data : '0;
      end
   end

   // R4: an accepted write leaves its line Modified
   p_write_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !snp_valid && cpu_write) |=> (st_vec[$past(cpu_idx)] == LS_MOD));

   // R5: a miss over a Modified line produces a write-back
   p_evict_mod_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !snp_valid && !cpu_hit && (cl_st == LS_MOD)) |=> wb_valid);

   // R6: a snooped read of a Modified line leaves it Valid
   p_snoop_read_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !snp_cmd && snp_hit && (sl_st == LS_MOD)) |=>
         (st_vec[$past(snp_idx)] == LS_VAL));

   // R6: supplied data always goes to memory as well
   p_supply_with_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (wb_valid && (wb_data == snp_data)));

   // R7: a snooped invalidate that hits clears the line
   p_snoop_inv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd && snp_hit) |=> (st_vec[$past(snp_idx)] == LS_INV));

   // R9: no bus request from a processor request that was not taken
   p_no_req_in_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> (cpu_valid && !snp_valid));
endmodule

// File: tb/tb_coh_snoop_ctl.sv
`timescale 1ns/1ps
module tb_coh_snoop_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 0, cpu_write = 0;
   logic [7:0]  cpu_addr = 0;
   logic [15:0] cpu_wdata = 0;
   logic        cpu_ready, cpu_done;
   logic [15:0] cpu_rdata;
   logic        bus_req_valid;
   logic [1:0]  bus_req_cmd;
   logic [7:0]  bus_req_addr;
   logic [15:0] bus_fill_data = 0;
   logic        snp_valid = 0, snp_cmd = 0;
   logic [7:0]  snp_addr = 0;
   logic        snp_supply, wb_valid;
   logic [15:0] snp_data, wb_data;
   logic [7:0]  wb_addr;

   int checks = 0, errors = 0;
   bit finished = 0, armed = 0;

   typedef struct {
      logic        done; logic [15:0] rdata;
      logic        wb;   logic [7:0]  wb_addr; logic [15:0] wb_data;
      logic        sup;  logic [15:0] sup_data;
      string       req;
   } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   coh_snoop_ctl dut (.*);

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: one cycle per call; checks same-cycle bus request, queues next-cycle outputs
   task automatic op(input logic cv, input logic cw, input logic [7:0] ca,
                     input logic [15:0] cd, input logic [15:0] fill,
                     input logic sv, input logic sc, input logic [7:0] sa,
                     input logic eb, input logic [1:0] ecmd,
                     input exp_t e);
      @(negedge clk);
      cpu_valid = cv; cpu_write = cw; cpu_addr = ca; cpu_wdata = cd;
      bus_fill_data = fill; snp_valid = sv; snp_cmd = sc; snp_addr = sa;
      #1;
      chk(e.req, "cpu_ready", cpu_ready, !sv);
      chk(e.req, "bus_req_valid", bus_req_valid, eb);
      if (eb) begin
         chk(e.req, "bus_req_cmd", bus_req_cmd, ecmd);
         chk(e.req, "bus_req_addr", bus_req_addr, ca);
      end
      q.push_back(e);
   endtask

   function automatic exp_t mk(input string r, input logic d, input logic [15:0] rd,
                               input logic w, input logic [7:0] wa, input logic [15:0] wd,
                               input logic s, input logic [15:0] sd);
      exp_t e;
      e.req = r; e.done = d; e.rdata = rd; e.wb = w; e.wb_addr = wa;
      e.wb_data = wd; e.sup = s; e.sup_data = sd;
      return e;
   endfunction

   // monitor: compares registered outputs after each edge
   initial begin
      forever begin
         @(posedge clk); #1;
         if (armed && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "cpu_done", cpu_done, e.done);
            if (e.done) chk(e.req, "cpu_rdata", cpu_rdata, e.rdata);
            chk(e.req, "wb_valid", wb_valid, e.wb);
            if (e.wb) begin
               chk(e.req, "wb_addr", wb_addr, e.wb_addr);
               chk(e.req, "wb_data", wb_data, e.wb_data);
            end
            chk(e.req, "snp_supply", snp_supply, e.sup);
            if (e.sup) chk(e.req, "snp_data", snp_data, e.sup_data);
         end
      end
   end

   initial begin
      repeat (4000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "cpu_done", cpu_done, 0);
      chk("R1", "wb_valid", wb_valid, 0);
      chk("R1", "snp_supply", snp_supply, 0);
      rst_n = 1'b1;
      armed = 1;
      // R1/R2: first read misses, fetches, line Valid
      op(1,0,8'h10,0,16'hAAAA, 0,0,0, 1,2'b01, mk("R2",1,16'hAAAA,0,0,0,0,0));
      // R3: read hit
      op(1,0,8'h10,0,16'h0000, 0,0,0, 0,0, mk("R3",1,16'hAAAA,0,0,0,0,0));
      // R4: write to Valid line -> read-exclusive
      op(1,1,8'h10,16'h1234,0, 0,0,0, 1,2'b10, mk("R4",1,0,0,0,0,0,0));
      // R4: write to Modified line -> no bus request
      op(1,1,8'h10,16'h5678,0, 0,0,0, 0,0, mk("R4",1,0,0,0,0,0,0));
      op(1,0,8'h10,0,0, 0,0,0, 0,0, mk("R3",1,16'h5678,0,0,0,0,0));
      // R6/R9: snoop read of Modified line, concurrent cpu request held off
      op(1,0,8'h21,0,16'hFFFF, 1,0,8'h10, 0,0, mk("R6_R9",0,0,1,8'h10,16'h5678,1,16'h5678));
      // R6/R8: second snoop read finds Valid -> nothing
      op(0,0,0,0,0, 1,0,8'h10, 0,0, mk("R8",0,0,0,0,0,0,0));
      op(1,0,8'h10,0,16'hFFFF, 0,0,0, 0,0, mk("R6",1,16'h5678,0,0,0,0,0));
      // R5: replace Valid line -> no write-back
      op(1,0,8'h14,0,16'h0BEE, 0,0,0, 1,2'b01, mk("R5",1,16'h0BEE,0,0,0,0,0));
      op(1,1,8'h14,16'h9999,0, 0,0,0, 1,2'b10, mk("R4",1,0,0,0,0,0,0));
      // R5: replace Modified line -> write-back of old line
      op(1,0,8'h18,0,16'h7777, 0,0,0, 1,2'b01, mk("R5",1,16'h7777,1,8'h14,16'h9999,0,0));
      // R4: write miss to an Invalid line
      op(1,1,8'h23,16'hCAFE,0, 0,0,0, 1,2'b10, mk("R4",1,0,0,0,0,0,0));
      // R7: snoop invalidate of Modified line
      op(0,0,0,0,0, 1,1,8'h23, 0,0, mk("R7",0,0,1,8'h23,16'hCAFE,1,16'hCAFE));
      op(1,0,8'h23,0,16'h1111, 0,0,0, 1,2'b01, mk("R7",1,16'h1111,0,0,0,0,0));
      // R7: snoop invalidate of Valid line -> silent, line gone
      op(0,0,0,0,0, 1,1,8'h23, 0,0, mk("R7",0,0,0,0,0,0,0));
      op(1,0,8'h23,0,16'h2222, 0,0,0, 1,2'b01, mk("R7",1,16'h2222,0,0,0,0,0));
      // R8: snoops with wrong tag or to an empty line leave state alone
      op(0,0,0,0,0, 1,1,8'h33, 0,0, mk("R8",0,0,0,0,0,0,0));
      op(0,0,0,0,0, 1,1,8'h31, 0,0, mk("R8",0,0,0,0,0,0,0));
      op(1,0,8'h23,0,16'hFFFF, 0,0,0, 0,0, mk("R8",1,16'h2222,0,0,0,0,0));
      op(0,0,0,0,0, 0,0,0, 0,0, mk("idle",0,0,0,0,0,0,0));
      @(posedge clk); #2;
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule